// File: doc/BRIEF.md
# DMA Width-Converting Pack/Unpack Buffer

This block is the data path of one DMA channel. A source side issues read requests of byte, half-word or word size, and the returned elements go into a byte-granular buffer of 16 words. A destination side reads that buffer back out as write requests of its own element size. The two sizes are chosen independently, so any of the nine size pairings moves the same byte stream. Each side has its own address generator. It either steps by its element size or holds a fixed address, which suits a peripheral data register.

Both request interfaces use valid/ready. A beat completes on a clock edge where valid and ready are both high. Read data arrives with the completing beat, and write data is valid whenever write valid is high. The two sides share one burst-length field. A burst on either side begins only when the buffer can take or supply the whole burst, so once started it never stalls on the buffer. An error response on any completed beat ends the transfer and raises a held interrupt.

Control is a channel state machine with states CH_IDLE, CH_RUN, CH_DONE and CH_FAULT. Its transitions are:
- start: CH_IDLE, CH_DONE or CH_FAULT to CH_RUN.
- drain: CH_RUN to CH_DONE.
- error: CH_RUN to CH_FAULT.

Each side runs a burst sequencer with states SQ_IDLE, SQ_WAIT and SQ_BEAT. Its transitions are:
- load: any state to SQ_WAIT.
- launch: SQ_WAIT to SQ_BEAT, when the burst fits.
- last beat: SQ_BEAT to SQ_WAIT.
- stop: SQ_WAIT or SQ_BEAT to SQ_IDLE, whenever the channel is not in CH_RUN.

Top module: `dma_pack_fifo`

## Requirements
- R1: After reset, busy, done, err_irq, rd_valid and wr_valid are all low. A start pulse while not busy latches every cfg_* input and raises busy on the next cycle.
- R2: Size codes are 0 for byte (1), 1 for half-word (2) and 2 for word (4). Code 3 behaves as word. rd_size and wr_size report the normalised code. A transfer issues exactly cfg_count completed source reads, and each read element is taken from the low bytes of rd_data.
- R3: Source bytes are packed little-endian: byte k of an element lands in lane k, and stream order is preserved. Each destination element carries the next bytes of the stream in its low lanes, and its unused upper lanes are zero, for all nine size pairings.
- R4: The buffer never holds more than 64 bytes. While writes are refused, the source stops after filling it.
- R5: With the increment flag set, a side's address advances by its element size after each completed beat. With the flag clear, the address stays at its start value.
- R6: cfg_burst holds the burst length minus one. A source burst of min(burst, elements left) begins only when the free space covers the whole burst. A destination burst begins only when the buffer holds burst × element bytes, or when the source has finished.
- R7: done rises once every source element has been read and fewer bytes than one destination element remain. Those leftover bytes are discarded. done stays high until the next start.
- R8: rd_err or wr_err on a completed beat moves the channel to fault. err_irq then stays high and no request is issued until the next start. An errored read is not stored.
- R9: A start pulse while busy is ignored, and the transfer in progress finishes with its original settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer with the cfg_* values |
| cfg_src_addr | input | ADDR_W | Source start address |
| cfg_dst_addr | input | ADDR_W | Destination start address |
| cfg_src_size | input | 2 | Source element size code |
| cfg_dst_size | input | 2 | Destination element size code |
| cfg_src_inc | input | 1 | Source address increments when high |
| cfg_dst_inc | input | 1 | Destination address increments when high |
| cfg_burst | input | BL_W | Burst length minus one |
| cfg_count | input | CNT_W | Number of source elements |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | ADDR_W | Read address |
| rd_size | output | 2 | Read size code |
| rd_ready | input | 1 | Read beat completes |
| rd_data | input | 32 | Read data, element in low lanes |
| rd_err | input | 1 | Error on the completing read |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | ADDR_W | Write address |
| wr_size | output | 2 | Write size code |
| wr_data | output | 32 | Write data, element in low lanes |
| wr_ready | input | 1 | Write beat completes |
| wr_err | input | 1 | Error on the completing write |
| busy | output | 1 | Channel in CH_RUN |
| done | output | 1 | Channel in CH_DONE |
| err_irq | output | 1 | Channel in CH_FAULT |

## Verification
The assertions check, on every cycle, the rules that hold beat by beat:
- The buffer stays within its 64-byte capacity, and no write is issued unless the buffer holds a full element.
- Each side's address steps correctly after every completed beat.
- Upper lanes stay zero on narrow writes.
- No requests appear outside CH_RUN.
- The fault and done indications hold until the next start.

Only the bench scenarios can show the rest. This covers byte-exact data order across every size pairing and increment mode, the exact read and write counts, and the leftover-byte discard. It also covers the burst start thresholds, the stall of the source once the buffer is full, and a start pulse being ignored during a run.

// File: rtl/dma_pf_pkg.sv
`timescale 1ns/1ps
package dma_pf_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_WAIT = 2'd1,
        SQ_BEAT = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_RUN   = 2'd1,
        CH_DONE  = 2'd2,
        CH_FAULT = 2'd3
    } chan_state_e;

    // size code to log2 of element bytes; code 3 is handled as a word
    function automatic logic [1:0] size_shift(input logic [1:0] code);
        return (code == 2'd0) ? 2'd0 : (code == 2'd1) ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/dma_byte_fifo.sv
`timescale 1ns/1ps
module dma_byte_fifo #(
    parameter int BYTES = 64,
    parameter int LVL_W = $clog2(BYTES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic [1:0]       push_shift,
    input  logic [31:0]      push_data,
    input  logic             pop,
    input  logic [1:0]       pop_shift,
    output logic [31:0]      pop_data,
    output logic [LVL_W-1:0] level
);
    localparam int PTR_W = $clog2(BYTES);

    logic [7:0]       mem [BYTES];
    logic [PTR_W-1:0] wptr, rptr;

    // pack: lane k of the incoming element goes to the next byte slot
    always_ff @(posedge clk) begin
        for (int k = 0; k < 4; k++) begin
            if (push && (k < (1 << push_shift))) begin
                mem[wptr + PTR_W'(k)] <= push_data[8*k +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else if (clear) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push) wptr <= wptr + PTR_W'(1 << push_shift);
            if (pop)  rptr <= rptr + PTR_W'(1 << pop_shift);
            level <= level + (push ? LVL_W'(1 << push_shift) : '0)
                           - (pop  ? LVL_W'(1 << pop_shift)  : '0);
        end
    end

    // unpack: oldest bytes into the low lanes, unused lanes zero
    always_comb begin
        for (int k = 0; k < 4; k++) begin
            pop_data[8*k +: 8] = (k < (1 << pop_shift)) ? mem[rptr + PTR_W'(k)] : 8'h00;
        end
    end

endmodule

// File: rtl/dma_burst_seq.sv
`timescale 1ns/1ps
module dma_burst_seq
    import dma_pf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BEAT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              stop,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              inc,
    input  logic [1:0]        shift,
    input  logic              can_start,
    input  logic [BEAT_W-1:0] beats,
    input  logic              ready,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic              waiting
);
    seq_state_e        st, st_nx;
    logic [BEAT_W-1:0] left_q;
    logic [ADDR_W-1:0] addr_q;
    logic              fire, launch;

    assign fire   = req_valid && ready;
    assign launch = (st == SQ_WAIT) && can_start && !stop;

    always_comb begin
        st_nx = st;
        if (load) begin
            st_nx = SQ_WAIT;
        end else begin
            unique case (st)
                SQ_IDLE: st_nx = SQ_IDLE;
                SQ_WAIT: if (stop) st_nx = SQ_IDLE;
                         else if (can_start) st_nx = SQ_BEAT;
                SQ_BEAT: if (stop) st_nx = SQ_IDLE;
                         else if (fire && left_q == BEAT_W'(1)) st_nx = SQ_WAIT;
                default: st_nx = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SQ_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
        end else begin
            if (load)             addr_q <= base_addr;
            else if (fire && inc) addr_q <= addr_q + (ADDR_W'(1) << shift);
            if (launch)           left_q <= beats;
            else if (fire)        left_q <= left_q - BEAT_W'(1);
        end
    end

    always_comb begin
        req_valid = (st == SQ_BEAT) && !stop;
        req_addr  = addr_q;
        waiting   = (st == SQ_WAIT);
    end

endmodule

// File: rtl/dma_pack_fifo.sv
`timescale 1ns/1ps
module dma_pack_fifo
    import dma_pf_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CNT_W       = 16,
    parameter int DEPTH_WORDS = 16,
    parameter int BL_W        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_src_addr,
    input  logic [ADDR_W-1:0] cfg_dst_addr,
    input  logic [1:0]        cfg_src_size,
    input  logic [1:0]        cfg_dst_size,
    input  logic              cfg_src_inc,
    input  logic              cfg_dst_inc,
    input  logic [BL_W-1:0]   cfg_burst,
    input  logic [CNT_W-1:0]  cfg_count,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        rd_size,
    input  logic              rd_ready,
    input  logic [31:0]       rd_data,
    input  logic              rd_err,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [1:0]        wr_size,
    output logic [31:0]       wr_data,
    input  logic              wr_ready,
    input  logic              wr_err,
    output logic              busy,
    output logic              done,
    output logic              err_irq
);
    localparam int FIFO_BYTES = 4 * DEPTH_WORDS;
    localparam int LVL_W      = $clog2(FIFO_BYTES) + 1;
    localparam int BEAT_W     = BL_W + 1;
    localparam int CMP_W      = BEAT_W + LVL_W + 2;

    chan_state_e      cs, cs_nx;
    logic [1:0]       src_sh_q, dst_sh_q;
    logic             src_inc_q, dst_inc_q;
    logic [BL_W-1:0]  burst_q;
    logic [CNT_W-1:0] src_left_q;

    logic              load, stop, rd_fire, wr_fire, push, pop, fault;
    logic [LVL_W-1:0]  level, space, dst_avail;
    logic [BEAT_W-1:0] burst_beats, src_beats, dst_beats;
    logic              src_done, src_can, dst_can, dst_waiting, drained;

    assign load    = start && (cs != CH_RUN);
    assign stop    = (cs != CH_RUN);
    assign rd_fire = rd_valid && rd_ready;
    assign wr_fire = wr_valid && wr_ready;
    assign push    = rd_fire && !rd_err;
    assign pop     = wr_fire && !wr_err;
    assign fault   = (rd_fire && rd_err) || (wr_fire && wr_err);

    // burst sizing and start thresholds for both sides
    assign burst_beats = BEAT_W'(burst_q) + BEAT_W'(1);
    assign src_done    = (src_left_q == '0);
    assign src_beats   = (src_left_q < CNT_W'(burst_beats)) ? BEAT_W'(src_left_q) : burst_beats;
    assign space       = LVL_W'(FIFO_BYTES) - level;
    assign src_can     = !src_done && (CMP_W'(space) >= (CMP_W'(src_beats) << src_sh_q));
    assign dst_avail   = level >> dst_sh_q;
    assign dst_beats   = (src_done && (CMP_W'(dst_avail) < CMP_W'(burst_beats)))
                         ? BEAT_W'(dst_avail) : burst_beats;
    assign dst_can     = (dst_beats != '0) && (CMP_W'(level) >= (CMP_W'(dst_beats) << dst_sh_q));
    assign drained     = src_done && dst_waiting && (dst_avail == '0);

    always_comb begin
        cs_nx = cs;
        unique case (cs)
            CH_IDLE, CH_DONE, CH_FAULT: if (start) cs_nx = CH_RUN;
            CH_RUN: if (fault) cs_nx = CH_FAULT;
                    else if (drained) cs_nx = CH_DONE;
            default: cs_nx = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs <= CH_IDLE;
        else        cs <= cs_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_sh_q   <= '0;
            dst_sh_q   <= '0;
            src_inc_q  <= 1'b0;
            dst_inc_q  <= 1'b0;
            burst_q    <= '0;
            src_left_q <= '0;
        end else if (load) begin
            src_sh_q   <= size_shift(cfg_src_size);
            dst_sh_q   <= size_shift(cfg_dst_size);
            src_inc_q  <= cfg_src_inc;
            dst_inc_q  <= cfg_dst_inc;
            burst_q    <= cfg_burst;
            src_left_q <= cfg_count;
        end else if (push) begin
            src_left_q <= src_left_q - CNT_W'(1);
        end
    end

    always_comb begin
        busy    = (cs == CH_RUN);
        done    = (cs == CH_DONE);
        err_irq = (cs == CH_FAULT);
        rd_size = src_sh_q;
        wr_size = dst_sh_q;
    end

    dma_byte_fifo #(.BYTES(FIFO_BYTES), .LVL_W(LVL_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clear(load),
        .push(push), .push_shift(src_sh_q), .push_data(rd_data),
        .pop(pop), .pop_shift(dst_sh_q), .pop_data(wr_data),
        .level(level)
    );

    logic src_waiting_unused;

    dma_burst_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_src (
        .clk(clk), .rst_n(rst_n), .load(load), .stop(stop),
        .base_addr(cfg_src_addr), .inc(src_inc_q), .shift(src_sh_q),
        .can_start(src_can), .beats(src_beats), .ready(rd_ready),
        .req_valid(rd_valid), .req_addr(rd_addr), .waiting(src_waiting_unused)
    );

    dma_burst_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dst (
        .clk(clk), .rst_n(rst_n), .load(load), .stop(stop),
        .base_addr(cfg_dst_addr), .inc(dst_inc_q), .shift(dst_sh_q),
        .can_start(dst_can), .beats(dst_beats), .ready(wr_ready),
        .req_valid(wr_valid), .req_addr(wr_addr), .waiting(dst_waiting)
    );

endmodule

// File: rtl/dma_pack_fifo_chk.sv
`timescale 1ns/1ps
module dma_pack_fifo_chk #(
    parameter int ADDR_W     = 32,
    parameter int LVL_W      = 7,
    parameter int FIFO_BYTES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              err_irq,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic              rd_err,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [1:0]        rd_size,
    input logic              src_inc,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              wr_err,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [1:0]        wr_size,
    input logic              dst_inc,
    input logic [31:0]       wr_data,
    input logic [LVL_W-1:0]  level
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_valid && !wr_valid));

    p_wr_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_size == 2'd0) |-> (wr_data[31:8] == 24'd0));

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (level >= (LVL_W'(1) << wr_size)));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(FIFO_BYTES));

    p_src_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && !rd_err) |=>
        (rd_addr == $past(rd_addr) + ($past(src_inc) ? (ADDR_W'(1) << $past(rd_size)) : '0)));

    p_dst_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready && !wr_err) |=>
        (wr_addr == $past(wr_addr) + ($past(dst_inc) ? (ADDR_W'(1) << $past(wr_size)) : '0)));

    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_rd_err_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && rd_err) |=> (err_irq && !rd_valid && !wr_valid));

    p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_irq && !start) |=> err_irq);

endmodule

bind dma_pack_fifo dma_pack_fifo_chk #(
    .ADDR_W(ADDR_W), .LVL_W(LVL_W), .FIFO_BYTES(FIFO_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .err_irq(err_irq), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_err(rd_err), .rd_addr(rd_addr), .rd_size(rd_size), .src_inc(src_inc_q),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_err(wr_err),
    .wr_addr(wr_addr), .wr_size(wr_size), .dst_inc(dst_inc_q),
    .wr_data(wr_data), .level(level)
);

// File: tb/dma_pack_fifo_tb.sv
`timescale 1ns/1ps
module dma_pack_fifo_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cfg_src_addr = '0, cfg_dst_addr = '0;
    logic [1:0]  cfg_src_size = '0, cfg_dst_size = '0;
    logic        cfg_src_inc = 1'b0, cfg_dst_inc = 1'b0;
    logic [3:0]  cfg_burst = '0;
    logic [15:0] cfg_count = '0;
    logic        rd_valid, wr_valid, busy, done, err_irq;
    logic [31:0] rd_addr, wr_addr, wr_data;
    logic [1:0]  rd_size, wr_size;
    logic        rd_ready = 1'b0, rd_err = 1'b0, wr_ready = 1'b0, wr_err = 1'b0;
    logic [31:0] rd_data = '0;

    always #2.5 clk = ~clk;

    dma_pack_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
        .cfg_src_size(cfg_src_size), .cfg_dst_size(cfg_dst_size),
        .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
        .cfg_burst(cfg_burst), .cfg_count(cfg_count),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_size(rd_size),
        .rd_ready(rd_ready), .rd_data(rd_data), .rd_err(rd_err),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_size(wr_size),
        .wr_data(wr_data), .wr_ready(wr_ready), .wr_err(wr_err),
        .busy(busy), .done(done), .err_irq(err_irq)
    );

    int checks = 0, fails = 0;
    bit finished = 0;

    // expectation state shared with the bus models
    logic [31:0] e_sbase = '0, e_dbase = '0;
    int  e_ssh = 0, e_dsh = 0;
    bit  e_sinc = 0, e_dinc = 0;
    int  n_rd = 0, n_wr = 0, seed = 0, first_wr_rd = -1;
    int  err_rd_at = -1, err_wr_at = -1;
    bit  rand_rdy = 0, hold_wr = 0;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] sbyte(input int j);
        return 8'((j * 37 + seed) & 255);
    endfunction

    function automatic logic [31:0] elem(input int idx, input int sh);
        logic [31:0] d = '0;
        for (int k = 0; k < 4; k++)
            if (k < (1 << sh)) d[8*k +: 8] = sbyte(idx * (1 << sh) + k);
        return d;
    endfunction

    // source and destination bus models, driven away from the rising edge
    always @(negedge clk) begin
        bit rr, rw;
        if (rst_n) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rr = rand_rdy ? (lfsr[0] | lfsr[1]) : 1'b1;
            rw = hold_wr ? 1'b0 : (rand_rdy ? (lfsr[2] | lfsr[3]) : 1'b1);
            if (wr_valid) begin
                if (first_wr_rd < 0) first_wr_rd = n_rd;
                chk(wr_addr == e_dbase + (e_dinc ? 32'(n_wr << e_dsh) : 32'd0), "R5 write address",
                    wr_addr, e_dbase + (e_dinc ? 32'(n_wr << e_dsh) : 32'd0));
                chk(wr_data == elem(n_wr, e_dsh), "R3 write data", wr_data, elem(n_wr, e_dsh));
                wr_err = (n_wr == err_wr_at) && rw;
                if (rw) n_wr++;
            end else begin
                wr_err = 1'b0;
            end
            wr_ready = rw;
            if (rd_valid) begin
                chk(rd_addr == e_sbase + (e_sinc ? 32'(n_rd << e_ssh) : 32'd0), "R5 read address",
                    rd_addr, e_sbase + (e_sinc ? 32'(n_rd << e_ssh) : 32'd0));
                chk(rd_size == 2'(e_ssh), "R2 read size", 32'(rd_size), 32'(e_ssh));
                rd_data = elem(n_rd, e_ssh);
                rd_err  = (n_rd == err_rd_at) && rr;
                if (rr) n_rd++;
            end else begin
                rd_data = '0;
                rd_err  = 1'b0;
            end
            rd_ready = rr;
        end
    end

    task automatic begin_xfer(input int scode, input int dcode, input bit si, input bit di,
                              input int bl, input int cnt);
        @(negedge clk);
        e_ssh = (scode == 3) ? 2 : scode;
        e_dsh = (dcode == 3) ? 2 : dcode;
        e_sinc = si; e_dinc = di;
        e_sbase = 32'h1000_0000 + 32'(checks * 16);
        e_dbase = 32'h2000_0100 + 32'(checks * 8);
        seed = checks + 3;
        n_rd = 0; n_wr = 0; first_wr_rd = -1;
        cfg_src_addr = e_sbase; cfg_dst_addr = e_dbase;
        cfg_src_size = 2'(scode); cfg_dst_size = 2'(dcode);
        cfg_src_inc = si; cfg_dst_inc = di;
        cfg_burst = 4'(bl); cfg_count = 16'(cnt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        for (int c = 0; c < 4000 && !(done || err_irq); c++) @(negedge clk);
    endtask

    task automatic full_xfer(input int scode, input int dcode, input bit si, input bit di,
                             input int bl, input int cnt, input string tag);
        int es, ed, nw;
        begin_xfer(scode, dcode, si, di, bl, cnt);
        chk(busy == 1'b1, "R1 busy after start", 32'(busy), 32'd1);
        wait_end();
        es = (scode == 3) ? 2 : scode;
        ed = (dcode == 3) ? 2 : dcode;
        nw = (cnt << es) >> ed;
        chk(done == 1'b1, {tag, " R7 done"}, 32'(done), 32'd1);
        chk(n_rd == cnt, {tag, " R2 read count"}, 32'(n_rd), 32'(cnt));
        chk(n_wr == nw, {tag, " R3 write count"}, 32'(n_wr), 32'(nw));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !err_irq, "R1 reset status", {29'd0, busy, done, err_irq}, 32'd0);
        chk(!rd_valid && !wr_valid, "R1 reset requests", {30'd0, rd_valid, wr_valid}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R5: all nine size pairings, four increment modes, three burst lengths
        rand_rdy = 1;
        for (int s = 0; s < 3; s++)
            for (int d = 0; d < 3; d++)
                for (int m = 0; m < 4; m++)
                    for (int b = 0; b < 3; b++)
                        full_xfer(s, d, m[0], m[1], (b == 0) ? 0 : (b == 1) ? 2 : 15, 48 >> s, "R3 sweep");

        // R2: size code 3 behaves as a word
        full_xfer(3, 0, 1, 1, 1, 6, "R2 code3");

        // R6: byte source, word destination, four-beat bursts need 16 bytes first
        rand_rdy = 0;
        full_xfer(0, 2, 1, 1, 3, 32, "R6 gate");
        chk(first_wr_rd >= 16, "R6 dst burst threshold", 32'(first_wr_rd), 32'd16);

        // R4: writes refused, source must stop at 16 words
        hold_wr = 1;
        begin_xfer(2, 0, 1, 1, 3, 30);
        repeat (200) @(negedge clk);
        chk(n_rd == 16, "R4 source stalls when full", 32'(n_rd), 32'd16);
        chk(n_wr == 0, "R4 no writes accepted", 32'(n_wr), 32'd0);
        hold_wr = 0;
        wait_end();
        chk(done && n_rd == 30 && n_wr == 120, "R4 completes after stall", 32'(n_wr), 32'd120);

        // R7: leftover bytes dropped, zero count, done held
        full_xfer(0, 2, 1, 1, 0, 7, "R7 leftover");
        repeat (3) @(negedge clk);
        chk(done && !busy, "R7 done held", {30'd0, done, busy}, 32'd2);
        full_xfer(1, 1, 1, 0, 0, 0, "R7 zero count");

        // R9: a second start while busy is ignored
        begin_xfer(0, 2, 1, 1, 0, 40);
        repeat (6) @(negedge clk);
        cfg_count = 16'd3; cfg_src_addr = 32'hDEAD_0000; cfg_src_size = 2'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_end();
        chk(done && n_rd == 40, "R9 restart ignored, reads", 32'(n_rd), 32'd40);
        chk(n_wr == 10, "R9 restart ignored, writes", 32'(n_wr), 32'd10);

        // R8: read error on the third read
        err_rd_at = 2;
        begin_xfer(2, 2, 1, 1, 0, 10);
        wait_end();
        err_rd_at = -1;
        chk(err_irq && !done, "R8 fault on read error", {30'd0, err_irq, done}, 32'd2);
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            chk(!rd_valid && !wr_valid && err_irq, "R8 quiet and held after fault",
                {29'd0, rd_valid, wr_valid, err_irq}, 32'd1);
        end
        // R8: write error on the first write
        err_wr_at = 0;
        begin_xfer(1, 2, 1, 1, 0, 8);
        wait_end();
        err_wr_at = -1;
        chk(err_irq && !done, "R8 fault on write error", {30'd0, err_irq, done}, 32'd2);
        // R8: next start clears the fault
        full_xfer(2, 1, 0, 1, 1, 5, "R8 recovery");
        chk(!err_irq, "R8 fault cleared", 32'(err_irq), 32'd0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule